// File: doc/BRIEF.md
# SD Command Line Sequencer

This block drives one command frame onto the serial command line of an SD/MMC card and, depending on a 2-bit response code, listens for the card's reply. A frame is 48 bits long. It holds a start bit, a direction bit, the 6-bit command index, the 32-bit argument, a CRC7 and a stop bit, and it is shifted out most significant bit first, one bit per clock. When a reply is expected, the block watches the line for a start bit. It then collects a 48-bit or a 136-bit response, checks its CRC where the code asks for it, and places the payload in four 32-bit words.

Some responses signal that the card is busy. For those the block can then watch data line 0. While the line stays low it holds a busy level. It reports busy-end when the line goes high, or a data timeout when a programmable number of low samples has been seen first. A marker input tags a command as one that aborts a running data transfer, and the block reports this when the frame finishes. Every result is a one-cycle pulse. A new command is only taken while the block is idle.

Top module: `sd_cmd_path`

## Requirements
- R1: A start accepted in cycle t drives cmd_oe_o high and sends 48 bits on cmd_o in cycles t+1 to t+48, most significant first. The bits are 0, 1, index[5:0], argument[31:0], CRC7 and 1. The CRC7 uses x^7+x^3+1, starts from zero and covers the first 40 bits. When idle, cmd_o is 1 and cmd_oe_o is 0.
- R2: With rsp_mode_i = 00 (no response), sent_o pulses in the cycle after the last frame bit, and no other result pulse follows.
- R3: With rsp_mode_i = 01 or 10, a 48-bit response is collected. Response bits 39..8 (bit 47 is the start bit) go to resp_w0_o. resp_w1_o to resp_w3_o keep their previous values.
- R4: With mode 01, the CRC7 over response bits 47..8 must equal bits 7..1. If it does, rsp_end_o pulses; if not, crc_fail_o pulses instead. With mode 10, rsp_end_o pulses without any CRC check.
- R5: With mode 11, a 136-bit response is collected. Response bits 127..0 fill resp_w0_o (bits 127..96) down to resp_w3_o (bits 31..0). The CRC7 over bits 127..8 must equal bits 7..1, with the same pulse rule as R4.
- R6: After the stop bit of the frame, the response start bit (cmd_i = 0) must be sampled within 64 cycles. A start bit on the 64th sample is accepted. If none comes, cmd_tmo_o pulses in the cycle after the 64th sample.
- R7: When busy_rsp_i was set with the command, the response passes, and dat0_i is 0 on its last bit, busy_o goes high. busy_end_o pulses in the cycle after the first sample with dat0_i = 1, and busy_o drops. If dat0_i is 1 on the last bit, there is no busy phase.
- R8: During busy, the k-th consecutive low sample with k >= dtimeout_i ends busy with data_tmo_o. A high sample always yields busy_end_o, even on the sample where the timer would expire.
- R9: abort_o pulses in the cycle after the last frame bit exactly when stop_i was set at the accepted start.
- R10: start_i is ignored while a frame, a response wait, a response or a busy phase is in progress. Inputs changed after acceptance do not alter the frame.
- R11: After reset, cmd_o = 1, cmd_oe_o = 0, all response words are zero and busy_o and all pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one line bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a command when idle |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| rsp_mode_i | input | 2 | 00 none, 01 short with CRC, 10 short without CRC, 11 long |
| busy_rsp_i | input | 1 | Response may be followed by busy on data line 0 |
| stop_i | input | 1 | Command aborts a data transfer |
| dtimeout_i | input | DTMR_W | Busy timeout in low samples |
| cmd_o | output | 1 | Serial command line out |
| cmd_oe_o | output | 1 | Command line drive enable |
| cmd_i | input | 1 | Serial command line in |
| dat0_i | input | 1 | Data line 0 in |
| resp_w0_o | output | 32 | Response word 0 (most significant) |
| resp_w1_o | output | 32 | Response word 1 |
| resp_w2_o | output | 32 | Response word 2 |
| resp_w3_o | output | 32 | Response word 3 |
| sent_o | output | 1 | Pulse: frame sent, no response expected |
| rsp_end_o | output | 1 | Pulse: response received and passed |
| crc_fail_o | output | 1 | Pulse: response CRC mismatch |
| cmd_tmo_o | output | 1 | Pulse: no response start bit in time |
| abort_o | output | 1 | Pulse: abort command frame finished |
| busy_o | output | 1 | Card holds data line 0 low |
| busy_end_o | output | 1 | Pulse: data line 0 released |
| data_tmo_o | output | 1 | Pulse: busy timer expired |

## Verification
Two pairs of events can fall on the same sample. The first is the release of data line 0 and the expiry of the busy timer. The bench raises dat0_i exactly on the sample whose count reaches dtimeout_i, and it expects busy_end_o with data_tmo_o silent. The second is the arrival of a response start bit and the end of the response window. The bench delays the start bit by 63 idle bits so that it lands on the 64th sample, and it expects a normal response with no cmd_tmo_o. A run with 64 idle bits must give the timeout one cycle after the 64th sample, and not before.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int FRAME_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int HDR_LEN   = 40;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX} cmd_state_e;
  typedef enum logic [1:0] {
    RSP_NONE        = 2'b00,
    RSP_SHORT       = 2'b01,
    RSP_SHORT_NOCRC = 2'b10,
    RSP_LONG        = 2'b11
  } rsp_mode_e;

  function automatic logic [6:0] crc7_step(logic [6:0] c, logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_hdr(logic [HDR_LEN-1:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = HDR_LEN - 1; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction
endpackage

// File: rtl/sd_crc7_ser.sv
module sd_crc7_ser import sd_cmd_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  logic [6:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc7_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sd_busy_wait.sv
module sd_busy_wait #(
  parameter int DTMR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              dat0_i,
  input  logic [DTMR_W-1:0] limit_i,
  output logic              act_o,
  output logic              end_o,
  output logic              tmo_o
);
  logic [DTMR_W-1:0] cnt_q, lim_q;
  logic              act_q, end_q, tmo_q;
  logic [DTMR_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
      act_q <= 1'b0;
      end_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      end_q <= 1'b0;
      tmo_q <= 1'b0;
      if (go_i) begin
        act_q <= 1'b1;
        cnt_q <= '0;
        lim_q <= limit_i;
      end else if (act_q) begin
        // release wins over expiry on the same sample
        if (dat0_i) begin
          act_q <= 1'b0;
          end_q <= 1'b1;
        end else if (cnt_inc >= {1'b0, lim_q}) begin
          act_q <= 1'b0;
          tmo_q <= 1'b1;
        end else begin
          cnt_q <= cnt_inc[DTMR_W-1:0];
        end
      end
    end
  end

  assign act_o = act_q;
  assign end_o = end_q;
  assign tmo_o = tmo_q;

  assert_busy_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(end_o && tmo_o));
  assert_busy_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> ($past(act_o) && !act_o));
  assert_busy_tmo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> ($past(act_o) && !$past(dat0_i)));
endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path import sd_cmd_pkg::*; #(
  parameter int DTMR_W  = 32,
  parameter int RSP_TMO = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [5:0]        cmd_idx_i,
  input  logic [31:0]       cmd_arg_i,
  input  logic [1:0]        rsp_mode_i,
  input  logic              busy_rsp_i,
  input  logic              stop_i,
  input  logic [DTMR_W-1:0] dtimeout_i,
  output logic              cmd_o,
  output logic              cmd_oe_o,
  input  logic              cmd_i,
  input  logic              dat0_i,
  output logic [31:0]       resp_w0_o,
  output logic [31:0]       resp_w1_o,
  output logic [31:0]       resp_w2_o,
  output logic [31:0]       resp_w3_o,
  output logic              sent_o,
  output logic              rsp_end_o,
  output logic              crc_fail_o,
  output logic              cmd_tmo_o,
  output logic              abort_o,
  output logic              busy_o,
  output logic              busy_end_o,
  output logic              data_tmo_o
);
  localparam int CNT_W = $clog2(LONG_LEN + 1);
  localparam int TMO_W = $clog2(RSP_TMO + 1);
  localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] LONG_CRC = CNT_W'(9);

  cmd_state_e            state_q;
  rsp_mode_e             mode_q;
  logic [FRAME_LEN-1:0]  tx_sh_q;
  logic [CNT_W-1:0]      cnt_q, n_rx;
  logic [TMO_W-1:0]      tmo_q;
  logic                  busy_req_q, stop_q;
  logic [127:0]          rx_sh_q, rx_nx;
  logic [3:0][31:0]      resp_q;
  logic                  sent_q, rend_q, crcf_q, ctmo_q, abort_q;

  logic [HDR_LEN-1:0]    hdr;
  logic [FRAME_LEN-1:0]  frame;
  logic                  is_long, rx_last, crc_en, crc_clr, rsp_ok;
  logic                  busy_go, busy_act, start_ok;
  logic [6:0]            crc_rx;

  assign hdr      = {2'b01, cmd_idx_i, cmd_arg_i};
  assign frame    = {hdr, crc7_hdr(hdr), 1'b1};
  assign is_long  = (mode_q == RSP_LONG);
  assign n_rx     = cnt_q + CNT_W'(1);
  assign rx_nx    = {rx_sh_q[126:0], cmd_i};
  assign rx_last  = n_rx == (is_long ? CNT_W'(LONG_LEN) : CNT_W'(FRAME_LEN));
  // long: bits 127..1, short: bits 47..1; the residue must be zero
  assign crc_en   = (state_q == ST_RX) &&
                    (is_long ? (n_rx >= LONG_CRC && n_rx <= CNT_W'(LONG_LEN - 1))
                             : (n_rx <= CNT_W'(FRAME_LEN - 1)));
  assign crc_clr  = (state_q == ST_WAIT) && !cmd_i;
  assign rsp_ok   = (mode_q == RSP_SHORT_NOCRC) || (crc_rx == 7'd0);
  assign busy_go  = (state_q == ST_RX) && rx_last && rsp_ok && busy_req_q && !dat0_i;
  assign start_ok = start_i && (state_q == ST_IDLE) && !busy_act;

  sd_crc7_ser u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (crc_en),
    .bit_i  (cmd_i),
    .crc_o  (crc_rx)
  );

  sd_busy_wait #(.DTMR_W(DTMR_W)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (busy_go),
    .dat0_i  (dat0_i),
    .limit_i (dtimeout_i),
    .act_o   (busy_act),
    .end_o   (busy_end_o),
    .tmo_o   (data_tmo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= RSP_NONE;
      tx_sh_q    <= '0;
      cnt_q      <= '0;
      tmo_q      <= '0;
      busy_req_q <= 1'b0;
      stop_q     <= 1'b0;
      rx_sh_q    <= '0;
      resp_q     <= '0;
      sent_q     <= 1'b0;
      rend_q     <= 1'b0;
      crcf_q     <= 1'b0;
      ctmo_q     <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      sent_q  <= 1'b0;
      rend_q  <= 1'b0;
      crcf_q  <= 1'b0;
      ctmo_q  <= 1'b0;
      abort_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q    <= ST_TX;
          tx_sh_q    <= frame;
          cnt_q      <= '0;
          mode_q     <= rsp_mode_e'(rsp_mode_i);
          busy_req_q <= busy_rsp_i;
          stop_q     <= stop_i;
        end
        ST_TX: begin
          tx_sh_q <= {tx_sh_q[FRAME_LEN-2:0], 1'b1};
          cnt_q   <= cnt_q + CNT_W'(1);
          if (cnt_q == TX_LAST) begin
            abort_q <= stop_q;
            tmo_q   <= '0;
            if (mode_q == RSP_NONE) begin
              sent_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (!cmd_i) begin
            state_q <= ST_RX;
            cnt_q   <= CNT_W'(1);
            rx_sh_q <= rx_nx;
          end else if (tmo_q == TMO_W'(RSP_TMO - 1)) begin
            ctmo_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            tmo_q <= tmo_q + TMO_W'(1);
          end
        end
        ST_RX: begin
          rx_sh_q <= rx_nx;
          cnt_q   <= n_rx;
          if (rx_last) begin
            state_q <= ST_IDLE;
            rend_q  <= rsp_ok;
            crcf_q  <= !rsp_ok;
            if (is_long) begin
              for (int w = 0; w < 4; w++) resp_q[w] <= rx_nx[127-32*w -: 32];
            end else begin
              resp_q[0] <= rx_nx[39:8];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_oe_o   = (state_q == ST_TX);
  assign cmd_o      = (state_q == ST_TX) ? tx_sh_q[FRAME_LEN-1] : 1'b1;
  assign resp_w0_o  = resp_q[0];
  assign resp_w1_o  = resp_q[1];
  assign resp_w2_o  = resp_q[2];
  assign resp_w3_o  = resp_q[3];
  assign sent_o     = sent_q;
  assign rsp_end_o  = rend_q;
  assign crc_fail_o = crcf_q;
  assign cmd_tmo_o  = ctmo_q;
  assign abort_o    = abort_q;
  assign busy_o     = busy_act;

  assert_start_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_oe_o) |-> !cmd_o);
  assert_sent_after_tx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_o |-> ($past(cmd_oe_o) && !cmd_oe_o));
  assert_abort_after_tx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(cmd_oe_o) && !cmd_oe_o));
  assert_result_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sent_o, rsp_end_o, crc_fail_o, cmd_tmo_o}));
  assert_tmo_undriven_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_tmo_o |-> (!cmd_oe_o && !$past(cmd_oe_o)));
  assert_busy_undriven_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_oe_o);
endmodule

// File: tb/sim_sd_cmd_path.sv
module sim_sd_cmd_path;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, busy_rsp = 1'b0, stop = 1'b0;
  logic [5:0]  idx = '0;
  logic [31:0] arg = '0;
  logic [1:0]  mode = '0;
  logic [31:0] dtmo = 32'd8;
  logic        cmd_in = 1'b1, dat0 = 1'b1;
  logic        cmd_out, cmd_oe, sent, rend, crcf, ctmo, abrt, busy, bend, dtmof;
  logic [31:0] w0, w1, w2, w3;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_w [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_path u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_idx_i(idx), .cmd_arg_i(arg),
    .rsp_mode_i(mode), .busy_rsp_i(busy_rsp), .stop_i(stop), .dtimeout_i(dtmo),
    .cmd_o(cmd_out), .cmd_oe_o(cmd_oe), .cmd_i(cmd_in), .dat0_i(dat0),
    .resp_w0_o(w0), .resp_w1_o(w1), .resp_w2_o(w2), .resp_w3_o(w3),
    .sent_o(sent), .rsp_end_o(rend), .crc_fail_o(crcf), .cmd_tmo_o(ctmo),
    .abort_o(abrt), .busy_o(busy), .busy_end_o(bend), .data_tmo_o(dtmof)
  );

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] bcrc(logic [135:0] v, int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic chk_words(string req);
    chk({w0, w1, w2, w3} == {exp_w[0], exp_w[1], exp_w[2], exp_w[3]}, req, "resp words",
        {w0, w1, w2, w3}, {exp_w[0], exp_w[1], exp_w[2], exp_w[3]});
  endtask

  // launch a command and check the frame and its end-of-frame pulses
  task automatic send_cmd(logic [5:0] i6, logic [31:0] a, logic [1:0] m, bit b, bit s, bit glitch);
    logic [39:0] hdr;
    logic [47:0] exp_f, got;
    bit oe_ok;
    hdr = {2'b01, i6, a};
    exp_f = {hdr, bcrc({96'd0, hdr}, 40), 1'b1};
    idx = i6; arg = a; mode = m; busy_rsp = b; stop = s;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    oe_ok = 1'b1;
    for (int k = 0; k < 48; k++) begin
      got[47-k] = cmd_out;
      if (!cmd_oe) oe_ok = 1'b0;
      if (glitch && k == 10) begin start = 1'b1; idx = ~i6; arg = ~a; stop = ~s; end
      if (glitch && k == 11) start = 1'b0;
      @(negedge clk);
    end
    chk(got == exp_f, glitch ? "R10" : "R1", "frame bits", got, exp_f);
    chk(oe_ok && !cmd_oe && cmd_out, "R1", "drive enable window", {oe_ok, cmd_oe}, 2'b10);
    chk(sent == (m == 2'b00), "R2", "sent pulse", sent, m == 2'b00);
    chk(abrt == s, "R9", "abort pulse", abrt, s);
    chk(!rend && !crcf && !ctmo, "R2", "no other pulse", {rend, crcf, ctmo}, 0);
  endtask

  task automatic drive_bits(logic [135:0] v, int len, int delay);
    for (int d = 0; d < delay; d++) begin cmd_in = 1'b1; @(negedge clk); end
    for (int k = len - 1; k >= 0; k--) begin cmd_in = v[k]; @(negedge clk); end
    cmd_in = 1'b1;
  endtask

  task automatic rsp_short(logic [5:0] i6, logic [31:0] c, bit bad, int delay, bit d0low);
    logic [39:0] h;
    logic [6:0] cr;
    logic [47:0] v;
    bit exp_ok;
    h = {2'b00, i6, c};
    cr = bcrc({96'd0, h}, 40) ^ (bad ? 7'h04 : 7'h00);
    v = {h, cr, 1'b1};
    if (d0low) dat0 = 1'b0;
    drive_bits({88'd0, v}, 48, delay);
    exp_ok = !bad || (mode == 2'b10);
    exp_w[0] = c;
    chk(rend == exp_ok, "R4", "short rsp_end", rend, exp_ok);
    chk(crcf == !exp_ok, "R4", "short crc_fail", crcf, !exp_ok);
    chk(!ctmo, "R6", "no timeout when started in window", ctmo, 0);
    chk_words("R3");
    chk(busy == (exp_ok && busy_rsp && d0low), "R7", "busy level", busy, exp_ok && busy_rsp && d0low);
  endtask

  task automatic rsp_long(logic [119:0] c, bit bad, int delay);
    logic [6:0] cr;
    logic [127:0] body;
    cr = bcrc({16'd0, c}, 120) ^ (bad ? 7'h40 : 7'h00);
    body = {c, cr, 1'b1};
    drive_bits({2'b00, 6'h3f, body}, 136, delay);
    exp_w[0] = body[127:96]; exp_w[1] = body[95:64];
    exp_w[2] = body[63:32];  exp_w[3] = body[31:0];
    chk(rend == !bad, "R5", "long rsp_end", rend, !bad);
    chk(crcf == bad, "R5", "long crc_fail", crcf, bad);
    chk_words("R5");
  endtask

  // rel = sample index that sees D0 high (0: never)
  task automatic busy_phase(int lim, int rel, bit poke);
    bit quiet;
    quiet = 1'b1;
    for (int s = 1; s <= lim; s++) begin
      if (s == rel) dat0 = 1'b1;
      if (poke && s == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (cmd_oe) quiet = 1'b0;
      if (s == rel) begin
        chk(bend && !dtmof && !busy, "R8", "release wins", {bend, dtmof, busy}, 3'b100);
        break;
      end else if (s == lim) begin
        chk(dtmof && !bend && !busy, "R8", "busy timer expiry", {bend, dtmof, busy}, 3'b010);
      end else begin
        chk(busy && !bend && !dtmof, "R7", "busy held", {bend, dtmof, busy}, 3'b001);
      end
    end
    dat0 = 1'b1;
    @(negedge clk);
    if (cmd_oe) quiet = 1'b0;
    chk(quiet, "R10", "start during busy ignored", cmd_oe, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int w = 0; w < 4; w++) exp_w[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!cmd_oe && cmd_out, "R11", "idle line", {cmd_oe, cmd_out}, 2'b01);
    chk_words("R11");
    chk({sent, rend, crcf, ctmo, abrt, busy, bend, dtmof} == 0, "R11", "pulses quiet",
        {sent, rend, crcf, ctmo, abrt, busy, bend, dtmof}, 0);

    // R2 R9: no response, abort marker
    send_cmd(6'd12, 32'h0, 2'b00, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk(!sent && !abrt, "R2", "single pulse", {sent, abrt}, 0);

    // R3: short with CRC, immediate start bit
    send_cmd(6'd17, 32'h0000_1234, 2'b01, 1'b0, 1'b0, 1'b0);
    rsp_short(6'd17, 32'hdead_beef, 1'b0, 0, 1'b0);
    // R4: bad CRC with check, then without check
    send_cmd(6'd13, 32'hffff_0000, 2'b01, 1'b0, 1'b0, 1'b0);
    rsp_short(6'd13, 32'h0bad_0c0c, 1'b1, 5, 1'b0);
    send_cmd(6'd41, 32'h00ff_8000, 2'b10, 1'b0, 1'b0, 1'b0);
    rsp_short(6'd63, 32'h5a5a_a5a5, 1'b1, 2, 1'b0);

    // R5: long response, then short keeps words 1..3 (R3)
    send_cmd(6'd2, 32'h0, 2'b11, 1'b0, 1'b0, 1'b0);
    rsp_long(120'h0123_4567_89ab_cdef_fedc_ba98_7654_32, 1'b0, 3);
    send_cmd(6'd7, 32'h1, 2'b01, 1'b0, 1'b0, 1'b0);
    rsp_short(6'd7, 32'h1357_9bdf, 1'b0, 1, 1'b0);
    send_cmd(6'd9, 32'h2, 2'b11, 1'b0, 1'b0, 1'b0);
    rsp_long(120'hffee_ddcc_bbaa_9988_7766_5544_3322_11, 1'b1, 0);

    // R6: start bit on the last window sample, then true timeout
    send_cmd(6'd55, 32'h3, 2'b01, 1'b0, 1'b0, 1'b0);
    rsp_short(6'd55, 32'hcafe_f00d, 1'b0, 63, 1'b0);
    send_cmd(6'd8, 32'h1aa, 2'b01, 1'b0, 1'b0, 1'b0);
    for (int d = 0; d < 63; d++) @(negedge clk);
    chk(!ctmo, "R6", "no early timeout", ctmo, 0);
    @(negedge clk);
    chk(ctmo && !rend && !crcf, "R6", "timeout pulse", {ctmo, rend, crcf}, 3'b100);
    @(negedge clk);
    chk(!ctmo, "R6", "timeout single cycle", ctmo, 0);

    // R7 R8: busy phases
    dtmo = 32'd10;
    send_cmd(6'd7, 32'h4, 2'b01, 1'b1, 1'b0, 1'b0);
    rsp_short(6'd7, 32'h0000_0900, 1'b0, 0, 1'b1);
    busy_phase(10, 3, 1'b1);
    dtmo = 32'd5;
    send_cmd(6'd12, 32'h0, 2'b01, 1'b1, 1'b1, 1'b0);
    rsp_short(6'd12, 32'h0000_0a00, 1'b0, 4, 1'b1);
    busy_phase(5, 0, 1'b0);
    dtmo = 32'd6;
    send_cmd(6'd38, 32'h5, 2'b10, 1'b1, 1'b0, 1'b0);
    rsp_short(6'd38, 32'h0000_0b00, 1'b0, 2, 1'b1);
    busy_phase(6, 6, 1'b0);
    send_cmd(6'd6, 32'h6, 2'b01, 1'b1, 1'b0, 1'b0);
    rsp_short(6'd6, 32'h0000_0c00, 1'b0, 0, 1'b0);
    @(negedge clk);
    chk(!busy && !bend && !dtmof, "R7", "no busy when D0 high", {busy, bend, dtmof}, 0);

    // R10: start and inputs changed during the frame
    send_cmd(6'd24, 32'h8765_4321, 2'b00, 1'b0, 1'b0, 1'b1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [1:0] m;
      bit bad, bz;
      m = 2'($urandom_range(0, 2));
      bad = ($urandom_range(0, 5) == 0);
      bz = ($urandom_range(0, 3) == 0) && !bad;
      dtmo = 32'($urandom_range(1, 12));
      send_cmd(6'($urandom), $urandom, m, bz, 1'($urandom), ($urandom_range(0, 7) == 0));
      if (m != 2'b00) begin
        rsp_short(6'($urandom), $urandom, bad, $urandom_range(0, 63), bz);
        if (busy) busy_phase(int'(dtmo), $urandom_range(0, int'(dtmo)), 1'b0);
      end
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule